// File: doc/BRIEF.md
# Serial-Bus Wiper Setting Target

This block is a target on a two-wire serial bus (I2C style) that owns a single 7-bit volatile setting: the code that positions a digital potentiometer wiper. Code 00h selects the zero-scale end of the ladder and 7Fh the full-scale end. The block runs on a fast system clock that oversamples the bus. Both bus lines pass through a synchroniser and a stability filter. Bus conditions and clock edges are then recovered from the filtered lines and fed to a frame engine. The engine matches a fixed 7-bit address, takes write bytes into the register and returns the register on reads.

The block drives SDA only through an active-high pull-low enable, in open-drain fashion. It never stretches SCL. Its output changes only after a programmable number of system clocks has passed since SCL fell. While the power-good input is low, the setting is forced to mid-scale and the bus interface stays idle and silent.

Top module: `wiper_i2c_target`

## Requirements
- R1: After synchronous reset the setting reads 3Fh and the pull-low enable is 0.
- R2: While `pwr_good` is 0 the setting is held at 3Fh, the pull-low enable stays 0, and complete frames on the bus are neither acknowledged nor applied.
- R3: A control byte with address bits [7:1] equal to `TARGET_ADDR` is acknowledged by pulling SDA low in the ninth clock. Any other nonzero control byte gets no acknowledge, and the data that follows it leaves the setting unchanged.
- R4: In a write frame (control bit 0 = 0), the low 7 bits of each data byte are committed when the target acknowledges that byte. Bit 7 of the data byte is ignored.
- R5: Several data bytes after one write control byte are each acknowledged, and each one overwrites the setting in turn.
- R6: A STOP or a repeated START that arrives before the eighth bit of a data byte has been clocked discards that byte, and the setting keeps its value.
- R7: In a read frame (control bit 0 = 1), every data byte is {1'b0, setting}, sent MSb first. A further byte follows each master acknowledge. After a master non-acknowledge the target releases SDA until the next START.
- R8: A START at any point, including a repeated START in the middle of a frame, restarts the address phase, so a new frame that follows it is decoded normally.
- R9: Control byte 00h is acknowledged. Every byte after it, up to the next STOP or START, is ignored: it is not acknowledged and the setting is not changed.
- R10: The pull-low enable does not change within `HOLD_CYC` system clocks after an SCL falling edge.
- R11: A pulse shorter than `FILT_LEN` system clocks on SCL or SDA is ignored. It adds no clock edge and creates no START or STOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversampling the bus |
| rst | input | 1 | Synchronous active-high reset |
| pwr_good | input | 1 | Supply-good indication; low forces default and idles the interface |
| scl_i | input | 1 | Serial clock line as seen at the pin |
| sda_i | input | 1 | Serial data line as seen at the pin |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |
| wiper_code | output | 7 | Current wiper setting |

## Verification
The bench builds the target with address 2Eh, a two-stage synchroniser, a 3-clock stability filter and a 4-clock output hold. It clocks the bus with a quarter period of 10 system clocks. Under these values the filter latency and the output hold fit inside one SCL low phase, so acknowledge and read-data timing can be exercised at full rate. A 2-clock spike on either line is shorter than the filter window and checks the rejection path. The short quarter period lets a few dozen random write, mismatch and read-back frames fit in the run alongside the directed abort, general-call and power-good cases.

// File: rtl/wiper_i2c_pkg.sv
package wiper_i2c_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_WR,
    ST_WR_ACK,
    ST_RD,
    ST_RD_ACK,
    ST_GC,
    ST_SKIP
  } frame_st_t;
endpackage

// File: rtl/wiper_line_filter.sv
module wiper_line_filter #(
  parameter int   SYNC_STAGES = 2,
  parameter int   STABLE_CYC  = 3,
  parameter logic IDLE_VAL    = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);
  localparam int CW = $clog2(STABLE_CYC + 1);

  logic [SYNC_STAGES-1:0] sync_q;
  logic [CW-1:0]          run_cnt;
  logic                   synced;

  assign synced = sync_q[SYNC_STAGES-1];

  always_ff @(posedge clk) begin
    if (rst) sync_q <= {SYNC_STAGES{IDLE_VAL}};
    else     sync_q <= {sync_q[SYNC_STAGES-2:0], din};
  end

  // dout follows the synchronised line only after STABLE_CYC equal samples
  always_ff @(posedge clk) begin
    if (rst) begin
      dout    <= IDLE_VAL;
      run_cnt <= '0;
    end else if (synced == dout) begin
      run_cnt <= '0;
    end else if (run_cnt == CW'(STABLE_CYC - 1)) begin
      dout    <= synced;
      run_cnt <= '0;
    end else begin
      run_cnt <= run_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/wiper_bus_events.sv
module wiper_bus_events (
  input  logic clk,
  input  logic rst,
  input  logic scl_f,
  input  logic sda_f,
  output logic start_ev,
  output logic stop_ev,
  output logic rise_ev,
  output logic fall_ev
);
  logic scl_d, sda_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_d <= 1'b1;
      sda_d <= 1'b1;
    end else begin
      scl_d <= scl_f;
      sda_d <= sda_f;
    end
  end

  assign start_ev = scl_d & scl_f & sda_d & ~sda_f;
  assign stop_ev  = scl_d & scl_f & ~sda_d & sda_f;
  assign rise_ev  = ~scl_d & scl_f;
  assign fall_ev  = scl_d & ~scl_f;
endmodule

// File: rtl/wiper_frame_engine.sv
module wiper_frame_engine
  import wiper_i2c_pkg::*;
#(
  parameter logic [6:0] TARGET_ADDR = 7'h2E,
  parameter int         WIDTH       = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             start_ev,
  input  logic             stop_ev,
  input  logic             rise_ev,
  input  logic             fall_ev,
  input  logic             sda_f,
  input  logic [WIDTH-1:0] rd_val,
  output logic             drive_req,
  output logic             wr_en,
  output logic [WIDTH-1:0] wr_data
);
  localparam int CNT_W = $clog2(BYTE_W + 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(BYTE_W);

  frame_st_t         state;
  logic [CNT_W-1:0]  bit_cnt;
  logic [BYTE_W-1:0] rx_sh;
  logic [BYTE_W-1:0] tx_sh;
  logic [BYTE_W-1:0] rd_byte;
  logic              rw_q;
  logic              gc_q;
  logic              mack_q;
  logic              shifting;

  assign rd_byte  = BYTE_W'(rd_val);
  assign shifting = (state == ST_ADDR) || (state == ST_WR) || (state == ST_RD);

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      state     <= ST_IDLE;
      bit_cnt   <= '0;
      rx_sh     <= '0;
      tx_sh     <= '0;
      rw_q      <= 1'b0;
      gc_q      <= 1'b0;
      mack_q    <= 1'b0;
      drive_req <= 1'b0;
      wr_en     <= 1'b0;
      wr_data   <= '0;
    end else begin
      wr_en <= 1'b0;
      if (start_ev) begin
        state     <= ST_ADDR;
        bit_cnt   <= '0;
        drive_req <= 1'b0;
      end else if (stop_ev) begin
        state     <= ST_IDLE;
        drive_req <= 1'b0;
      end else begin
        if (rise_ev) begin
          if (shifting && bit_cnt != FULL) begin
            rx_sh   <= {rx_sh[BYTE_W-2:0], sda_f};
            bit_cnt <= bit_cnt + 1'b1;
          end
          if (state == ST_RD_ACK) mack_q <= ~sda_f;
        end
        if (fall_ev) begin
          unique case (state)
            ST_ADDR: if (bit_cnt == FULL) begin
              if (rx_sh[BYTE_W-1:1] == TARGET_ADDR) begin
                state     <= ST_ADDR_ACK;
                drive_req <= 1'b1;
                rw_q      <= rx_sh[0];
                gc_q      <= 1'b0;
              end else if (rx_sh == '0) begin
                state     <= ST_ADDR_ACK;
                drive_req <= 1'b1;
                rw_q      <= 1'b0;
                gc_q      <= 1'b1;
              end else begin
                state     <= ST_SKIP;
              end
            end
            ST_ADDR_ACK: begin
              bit_cnt <= '0;
              if (gc_q) begin
                state     <= ST_GC;
                drive_req <= 1'b0;
              end else if (rw_q) begin
                state     <= ST_RD;
                tx_sh     <= rd_byte;
                drive_req <= ~rd_byte[BYTE_W-1];
              end else begin
                state     <= ST_WR;
                drive_req <= 1'b0;
              end
            end
            ST_WR: if (bit_cnt == FULL) begin
              state     <= ST_WR_ACK;
              wr_en     <= 1'b1;
              wr_data   <= rx_sh[WIDTH-1:0];
              drive_req <= 1'b1;
            end
            ST_WR_ACK: begin
              state     <= ST_WR;
              bit_cnt   <= '0;
              drive_req <= 1'b0;
            end
            ST_RD: begin
              if (bit_cnt == FULL) begin
                state     <= ST_RD_ACK;
                mack_q    <= 1'b0;
                drive_req <= 1'b0;
              end else begin
                tx_sh     <= {tx_sh[BYTE_W-2:0], 1'b0};
                drive_req <= ~tx_sh[BYTE_W-2];
              end
            end
            ST_RD_ACK: begin
              if (mack_q) begin
                state     <= ST_RD;
                bit_cnt   <= '0;
                tx_sh     <= rd_byte;
                drive_req <= ~rd_byte[BYTE_W-1];
              end else begin
                state     <= ST_SKIP;
                drive_req <= 1'b0;
              end
            end
            default: ;
          endcase
        end
      end
    end
  end
endmodule

// File: rtl/wiper_sda_hold.sv
module wiper_sda_hold #(
  parameter int HOLD_CYC = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic fall_ev,
  input  logic drive_req,
  output logic sda_oe
);
  localparam int HW = $clog2(HOLD_CYC + 1);
  logic [HW-1:0] hold_cnt;

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      hold_cnt <= '0;
      sda_oe   <= 1'b0;
    end else begin
      if (fall_ev)             hold_cnt <= HW'(HOLD_CYC);
      else if (hold_cnt != '0) hold_cnt <= hold_cnt - 1'b1;
      if (hold_cnt == '0) sda_oe <= drive_req;
    end
  end
endmodule

// File: rtl/wiper_i2c_target.sv
module wiper_i2c_target #(
  parameter logic [6:0] TARGET_ADDR  = 7'h2E,
  parameter int         WIDTH        = 7,
  parameter logic [6:0] DEFAULT_CODE = 7'h3F,
  parameter int         SYNC_STAGES  = 2,
  parameter int         FILT_LEN     = 3,
  parameter int         HOLD_CYC     = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             pwr_good,
  input  logic             scl_i,
  input  logic             sda_i,
  output logic             sda_oe,
  output logic [WIDTH-1:0] wiper_code
);
  localparam int LINES = 2;

  logic [LINES-1:0] raw_lines, filt_lines;
  logic scl_f, sda_f;
  logic start_ev, stop_ev, rise_ev, fall_ev;
  logic drive_req, wr_en;
  logic [WIDTH-1:0] wr_data;

  assign raw_lines = {sda_i, scl_i};
  assign scl_f = filt_lines[0];
  assign sda_f = filt_lines[1];

  for (genvar g = 0; g < LINES; g++) begin : g_line
    wiper_line_filter #(
      .SYNC_STAGES(SYNC_STAGES), .STABLE_CYC(FILT_LEN), .IDLE_VAL(1'b1)
    ) u_filt (
      .clk(clk), .rst(rst), .din(raw_lines[g]), .dout(filt_lines[g])
    );
  end

  wiper_bus_events u_events (
    .clk(clk), .rst(rst), .scl_f(scl_f), .sda_f(sda_f),
    .start_ev(start_ev), .stop_ev(stop_ev), .rise_ev(rise_ev), .fall_ev(fall_ev)
  );

  wiper_frame_engine #(.TARGET_ADDR(TARGET_ADDR), .WIDTH(WIDTH)) u_engine (
    .clk(clk), .rst(rst), .en(pwr_good),
    .start_ev(start_ev), .stop_ev(stop_ev), .rise_ev(rise_ev), .fall_ev(fall_ev),
    .sda_f(sda_f), .rd_val(wiper_code),
    .drive_req(drive_req), .wr_en(wr_en), .wr_data(wr_data)
  );

  wiper_sda_hold #(.HOLD_CYC(HOLD_CYC)) u_hold (
    .clk(clk), .rst(rst), .en(pwr_good), .fall_ev(fall_ev),
    .drive_req(drive_req), .sda_oe(sda_oe)
  );

  always_ff @(posedge clk) begin
    if (rst || !pwr_good) wiper_code <= WIDTH'(DEFAULT_CODE);
    else if (wr_en)       wiper_code <= wr_data;
  end
endmodule

// File: rtl/wiper_i2c_checker.sv
module wiper_i2c_checker #(
  parameter int         WIDTH    = 7,
  parameter logic [6:0] DEF_CODE = 7'h3F,
  parameter int         HOLD_CYC = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             pwr_good,
  input logic             scl_f,
  input logic             sda_oe,
  input logic [WIDTH-1:0] wiper_code
);
  localparam int SW = $clog2(HOLD_CYC + 2);
  localparam logic [SW-1:0] SAT = SW'(HOLD_CYC + 1);

  logic [SW-1:0] since_fall;
  logic          scl_prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      since_fall <= SAT;
      scl_prev   <= 1'b1;
    end else begin
      scl_prev <= scl_f;
      if (scl_prev && !scl_f)   since_fall <= '0;
      else if (since_fall != SAT) since_fall <= since_fall + 1'b1;
    end
  end

  assert_reset_state_R1: assert property (@(posedge clk)
    rst |=> (wiper_code == WIDTH'(DEF_CODE) && !sda_oe));

  assert_pg_default_R2: assert property (@(posedge clk) disable iff (rst)
    !pwr_good |=> (wiper_code == WIDTH'(DEF_CODE) && !sda_oe));

  // R4: commits happen only from an SCL falling edge, so the code moves while SCL is low
  assert_commit_scl_low_R4: assert property (@(posedge clk) disable iff (rst)
    (pwr_good && $past(pwr_good) && wiper_code != $past(wiper_code)) |-> !scl_f);

  assert_output_hold_R10: assert property (@(posedge clk) disable iff (rst || !pwr_good)
    (sda_oe != $past(sda_oe)) |-> (since_fall >= SW'(HOLD_CYC)));
endmodule

bind wiper_i2c_target wiper_i2c_checker #(
  .WIDTH(WIDTH), .DEF_CODE(DEFAULT_CODE), .HOLD_CYC(HOLD_CYC)
) u_checker (
  .clk(clk), .rst(rst), .pwr_good(pwr_good), .scl_f(scl_f),
  .sda_oe(sda_oe), .wiper_code(wiper_code)
);

// File: tb/wiper_i2c_target_bench.sv
module wiper_i2c_target_bench;
  localparam logic [6:0] ADDR = 7'h2E;
  localparam int HOLD = 4;
  localparam int Q = 10;
  localparam int WDOG = 190000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic pwr_good = 1'b1;
  logic m_scl = 1'b1;
  logic m_sda_low = 1'b0;
  logic sda_oe;
  logic [6:0] wiper_code;
  wire sda_line = ~(m_sda_low | sda_oe);

  int n_checks = 0;
  int n_fail = 0;
  bit finished = 0;
  int ack_lat;
  logic [6:0] exp_w;

  always #5 clk = ~clk;

  wiper_i2c_target #(.TARGET_ADDR(ADDR), .HOLD_CYC(HOLD), .FILT_LEN(3)) u_wiper_i2c_target (
    .clk(clk), .rst(rst), .pwr_good(pwr_good), .scl_i(m_scl), .sda_i(sda_line),
    .sda_oe(sda_oe), .wiper_code(wiper_code)
  );

  function automatic logic [6:0] f_commit(input logic [7:0] d);
    return d[6:0];
  endfunction

  function automatic logic [7:0] f_rd_byte(input logic [6:0] w);
    return {1'b0, w};
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_start();
    if (!m_scl) begin
      wait_n(Q); m_sda_low = 1'b0;
      wait_n(Q); m_scl = 1'b1;
      wait_n(Q);
    end
    m_sda_low = 1'b1;
    wait_n(Q); m_scl = 1'b0;
  endtask

  task automatic do_stop();
    wait_n(Q); m_sda_low = 1'b1;
    wait_n(Q); m_scl = 1'b1;
    wait_n(Q); m_sda_low = 1'b0;
    wait_n(Q);
  endtask

  task automatic send_bit(input bit b, input bit glitch);
    if (glitch) begin
      wait_n(2); m_scl = 1'b1; wait_n(2); m_scl = 1'b0; wait_n(Q - 4);
    end else wait_n(Q);
    m_sda_low = ~b;
    wait_n(Q); m_scl = 1'b1;
    if (glitch && b) begin
      wait_n(3); m_sda_low = 1'b1; wait_n(2); m_sda_low = 1'b0; wait_n(Q - 5);
    end else wait_n(Q);
    wait_n(Q); m_scl = 1'b0;
  endtask

  // 8 bits plus the target's acknowledge slot; ack = 1 when SDA was low
  task automatic send_byte(input logic [7:0] d, input bit glitch, output bit ack);
    bit seen;
    for (int i = 7; i >= 0; i--) send_bit(d[i], glitch);
    m_sda_low = 1'b0;
    seen = 0; ack_lat = 2 * Q;
    for (int k = 0; k < 2 * Q; k++) begin
      @(negedge clk);
      if (!seen && sda_oe) begin seen = 1; ack_lat = k; end
    end
    m_scl = 1'b1;
    wait_n(Q); ack = ~sda_line;
    wait_n(Q); m_scl = 1'b0;
  endtask

  task automatic read_byte(input bit mack, output logic [7:0] v);
    m_sda_low = 1'b0;
    for (int i = 7; i >= 0; i--) begin
      wait_n(2 * Q); m_scl = 1'b1;
      wait_n(Q); v[i] = sda_line;
      wait_n(Q); m_scl = 1'b0;
    end
    wait_n(Q); m_sda_low = mack;
    wait_n(Q); m_scl = 1'b1;
    wait_n(2 * Q); m_scl = 1'b0;
    wait_n(2); m_sda_low = 1'b0;
  endtask

  task automatic wr_frame(input logic [6:0] a, input logic [7:0] d, output bit aack, output bit dack);
    do_start();
    send_byte({a, 1'b0}, 1'b0, aack);
    send_byte(d, 1'b0, dack);
    do_stop();
  endtask

  task automatic rd_frame(input logic [6:0] a, output bit aack, output logic [7:0] v);
    do_start();
    send_byte({a, 1'b1}, 1'b0, aack);
    read_byte(1'b0, v);
    do_stop();
  endtask

  task automatic readback(input string req);
    bit a; logic [7:0] v;
    rd_frame(ADDR, a, v);
    check(a, req, a, 1);
    check(v == f_rd_byte(exp_w), req, v, f_rd_byte(exp_w));
  endtask

  initial begin : watchdog
    for (int c = 0; c < WDOG; c++) begin
      @(posedge clk);
      if (finished) disable watchdog;
    end
    n_fail++;
    $display("FAIL watchdog actual=%0h expected=%0h", WDOG, 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    bit a, d;
    logic [7:0] v0, v1;
    int seed_val;
    seed_val = $urandom(32'h5EED);
    wait_n(4); rst = 1'b0; wait_n(2);
    exp_w = 7'h3F;
    check(wiper_code == 7'h3F, "R1", wiper_code, 7'h3F);
    check(sda_oe == 1'b0, "R1", sda_oe, 0);

    // R4: MSb of data ignored; R10: acknowledge waits HOLD cycles after SCL falls
    wr_frame(ADDR, 8'hD5, a, d);
    exp_w = f_commit(8'hD5);
    check(a && d, "R4", {a, d}, 3);
    check(wiper_code == exp_w, "R4", wiper_code, exp_w);
    check(ack_lat >= HOLD, "R10", ack_lat, HOLD);

    // R3: mismatching address, no acknowledge, no change
    wr_frame(ADDR ^ 7'h01, 8'h11, a, d);
    check(!a, "R3", a, 0);
    check(wiper_code == exp_w, "R3", wiper_code, exp_w);

    // R5: three data bytes in one frame
    do_start();
    send_byte({ADDR, 1'b0}, 1'b0, a);
    send_byte(8'h01, 1'b0, d);
    check(d && wiper_code == 7'h01, "R5", wiper_code, 7'h01);
    send_byte(8'h7E, 1'b0, d);
    check(d && wiper_code == 7'h7E, "R5", wiper_code, 7'h7E);
    send_byte(8'h22, 1'b0, d);
    check(d && wiper_code == 7'h22, "R5", wiper_code, 7'h22);
    do_stop();
    exp_w = 7'h22;

    // R6: STOP mid-byte discards
    do_start();
    send_byte({ADDR, 1'b0}, 1'b0, a);
    for (int i = 0; i < 5; i++) send_bit(1'b1, 1'b0);
    do_stop();
    check(wiper_code == exp_w, "R6", wiper_code, exp_w);

    // R6/R8: repeated START mid-byte discards, then the new frame decodes
    do_start();
    send_byte({ADDR, 1'b0}, 1'b0, a);
    for (int i = 0; i < 7; i++) send_bit(1'b0, 1'b0);
    do_start();
    check(wiper_code == exp_w, "R6", wiper_code, exp_w);
    send_byte({ADDR, 1'b0}, 1'b0, a);
    send_byte(8'h4C, 1'b0, d);
    do_stop();
    exp_w = 7'h4C;
    check(a && d && wiper_code == exp_w, "R8", wiper_code, exp_w);

    // R7: two-byte read, master acks first and nacks second
    do_start();
    send_byte({ADDR, 1'b1}, 1'b0, a);
    read_byte(1'b1, v0);
    read_byte(1'b0, v1);
    wait_n(Q);
    check(sda_line == 1'b1, "R7", sda_line, 1);
    do_stop();
    check(v0 == f_rd_byte(exp_w), "R7", v0, f_rd_byte(exp_w));
    check(v1 == f_rd_byte(exp_w), "R7", v1, f_rd_byte(exp_w));

    // R9: general call acknowledged, following byte ignored
    do_start();
    send_byte(8'h00, 1'b0, a);
    send_byte(8'h06, 1'b0, d);
    do_stop();
    check(a, "R9", a, 1);
    check(!d && wiper_code == exp_w, "R9", wiper_code, exp_w);

    // R11: spikes on SCL (low phase) and SDA (high phase) rejected
    do_start();
    send_byte({ADDR, 1'b0}, 1'b0, a);
    send_byte(8'h55, 1'b1, d);
    do_stop();
    exp_w = f_commit(8'h55);
    check(d && wiper_code == exp_w, "R11", wiper_code, exp_w);

    // R2: power-good low forces default and silences the interface
    pwr_good = 1'b0;
    wait_n(3);
    check(wiper_code == 7'h3F, "R2", wiper_code, 7'h3F);
    wr_frame(ADDR, 8'h10, a, d);
    check(!a && !d, "R2", {a, d}, 0);
    check(wiper_code == 7'h3F && !sda_oe, "R2", wiper_code, 7'h3F);
    pwr_good = 1'b1;
    wait_n(Q);
    exp_w = 7'h3F;
    readback("R2");

    // random mix of matching writes and foreign addresses, each read back
    for (int it = 0; it < 24; it++) begin
      logic [7:0] dat;
      logic [6:0] ad;
      dat = 8'($urandom);
      if (($urandom % 4) == 3) begin
        ad = 7'($urandom);
        if (ad == ADDR || ad == 7'h00) ad = ADDR ^ 7'h11;
        wr_frame(ad, dat, a, d);
        check(!a, "R3", a, 0);
      end else begin
        wr_frame(ADDR, dat, a, d);
        exp_w = f_commit(dat);
        check(a && d, "R4", {a, d}, 3);
      end
      readback("R7");
    end

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule